// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Source

This block stands in for a serial configuration memory that feeds a programmable-logic device. A bitstream is first written bit by bit into an internal array through a write port. The block then presents that stream one bit per rising edge of the configuration clock. It uses a single reset/output-enable control and an active-low chip enable. The shared data line is tri-stateable, and it is modelled as a data bit plus a drive-enable flag.

When the last stored bit has gone out, the block releases the line and pulls its active-low chip-enable-out low. When that output is wired to the chip enable of a second instance, the second instance continues the stream in the next cycle, and the two never drive the line at the same time. A synchronous power-on reset stands for the automatic clear at power-up.

Top module: `cfg_bitsrc`

## Requirements
- R1: While `rst_oe` is high, `dout_en` is low in that same cycle, and after the next rising edge the read position is address 0 with the end-of-stream condition cleared.
- R2: With `rst_oe` low and `ce_n` high, `dout_en` is low and the read position does not move: when `ce_n` later goes low, the stream resumes at the bit where it stopped.
- R3: With `rst_oe` low, `ce_n` low and the stream not finished, `dout_en` is high and `dout` shows the stored bit at the current address. The address rises by one on each rising edge. The first bit after a reset is address 0.
- R4: `rst_oe` high resets the read position and keeps `dout_en` low whatever the level of `ce_n`.
- R5: The edge that moves past the last address (DEPTH-1) ends the stream. From that edge on, `ceo_n` is low and `dout_en` stays low, and this holds until a reset.
- R6: `por` high at a rising edge clears the read position and the end-of-stream condition, and it holds `dout_en` low and `ceo_n` high while it is asserted.
- R7: `wr_en` high at a rising edge stores `wr_bit` at address `wr_addr`, and that bit is what `dout` later shows at that address. Address 0 is sent first.
- R8: When two instances are chained (the first one's `ceo_n` drives the second one's `ce_n`), the shared line carries the first memory's DEPTH bits and then the second's, with no gap and with at most one `dout_en` high in any cycle.
- R9: `ceo_n` is high in every cycle in which `rst_oe` is high, including after the stream has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock, rising edge active |
| por | input | 1 | Synchronous power-on reset, active high |
| wr_en | input | 1 | Write strobe for the bit store |
| wr_addr | input | AW | Bit address for a write |
| wr_bit | input | 1 | Bit value to store |
| rst_oe | input | 1 | High: reset and release the line; low: output enable |
| ce_n | input | 1 | Chip enable, active low |
| dout | output | 1 | Serial data bit at the current address |
| dout_en | output | 1 | High when this instance drives the data line |
| ceo_n | output | 1 | Chip-enable-out, active low, asserted after the last bit |

## Verification
The embedded properties expect `por` to be high at the first clock edge, so that the counter state is defined before any property is evaluated. They also expect writes to target addresses below DEPTH. The bench raises `por` for the opening cycles and only writes addresses in range. It changes `rst_oe`, `ce_n` and the write port only at falling edges, so every control level is settled before the edge that samples it. In the chained setup the second instance's chip enable comes only from the first instance's `ceo_n`, which is the only wiring under which the properties about handover hold.

// File: rtl/cfg_bitsrc_pkg.sv
package cfg_bitsrc_pkg;

    // Command presented to the read-position counter each cycle.
    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_STEP  = 2'd2
    } cnt_cmd_e;

endpackage

// File: rtl/cfg_bitsrc_store.sv
module cfg_bitsrc_store #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] mem_d;
    logic [DEPTH-1:0] mem_q;

    // One storage cell per bit; each cell loads only on its own address.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        assign mem_d[g] = (wr_en && (wr_addr == AW'(g))) ? wr_bit : mem_q[g];
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_bit = mem_q[rd_addr];

    // A write becomes visible at the read port for that address.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (por)
        (wr_en && (wr_addr < AW'(DEPTH - 1) || wr_addr == AW'(DEPTH - 1)))
        |=> (mem_q[$past(wr_addr)] == $past(wr_bit)))
        else $error("R7: written bit not stored");

endmodule

// File: rtl/cfg_bitsrc_counter.sv
module cfg_bitsrc_counter
    import cfg_bitsrc_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por,
    input  cnt_cmd_e      cmd,
    output logic [AW-1:0] addr,
    output logic          done
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          done;
    } cnt_st_t;

    cnt_st_t st_d;
    cnt_st_t st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CNT_CLEAR: st_d = '0;
            CNT_STEP: begin
                if (!st_q.done) begin
                    if (st_q.addr == LAST) begin
                        st_d.done = 1'b1;
                    end else begin
                        st_d.addr = st_q.addr + 1'b1;
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr = st_q.addr;
    assign done = st_q.done;

    p_clear_r1: assert property (@(posedge clk) disable iff (por)
        (cmd == CNT_CLEAR) |=> (addr == '0 && !done))
        else $error("R1: clear did not zero the counter");

    p_hold_r2: assert property (@(posedge clk) disable iff (por)
        (cmd == CNT_HOLD) |=> ($stable(addr) && $stable(done)))
        else $error("R2: counter moved while held");

    p_step_r3: assert property (@(posedge clk) disable iff (por)
        (cmd == CNT_STEP && !done && addr != LAST) |=> (addr == $past(addr) + 1'b1))
        else $error("R3: counter did not advance");

    p_end_r5: assert property (@(posedge clk) disable iff (por)
        (cmd == CNT_STEP && addr == LAST) |=> done)
        else $error("R5: end of stream not flagged");

endmodule

// File: rtl/cfg_bitsrc_ctrl.sv
module cfg_bitsrc_ctrl
    import cfg_bitsrc_pkg::*;
(
    input  logic     por,
    input  logic     rst_oe,
    input  logic     ce_n,
    input  logic     done,
    output cnt_cmd_e cmd,
    output logic     drive,
    output logic     ceo_n
);

    logic in_reset;

    always_comb begin
        in_reset = por || rst_oe;
        if (in_reset) begin
            cmd = CNT_CLEAR;
        end else if (!ce_n) begin
            cmd = CNT_STEP;
        end else begin
            cmd = CNT_HOLD;
        end
        drive = !in_reset && !ce_n && !done;
        ceo_n = in_reset || !done;
    end

endmodule

// File: rtl/cfg_bitsrc.sv
module cfg_bitsrc
    import cfg_bitsrc_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic          rst_oe,
    input  logic          ce_n,
    output logic          dout,
    output logic          dout_en,
    output logic          ceo_n
);

    cnt_cmd_e      cmd;
    logic [AW-1:0] rd_addr;
    logic          done;
    logic          drive;

    cfg_bitsrc_ctrl u_ctrl (
        .por    (por),
        .rst_oe (rst_oe),
        .ce_n   (ce_n),
        .done   (done),
        .cmd    (cmd),
        .drive  (drive),
        .ceo_n  (ceo_n)
    );

    cfg_bitsrc_counter #(.DEPTH(DEPTH), .AW(AW)) u_counter (
        .clk  (clk),
        .por  (por),
        .cmd  (cmd),
        .addr (rd_addr),
        .done (done)
    );

    cfg_bitsrc_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .por     (por),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (rd_addr),
        .rd_bit  (dout)
    );

    assign dout_en = drive;

    // Counter end flag and output stage are separate logic: once finished, the line is free.
    p_quiet_when_done_r5: assert property (@(posedge clk) disable iff (por)
        done |-> (!dout_en && (rst_oe || !ceo_n)))
        else $error("R5: line driven after end of stream");

    p_ceo_release_r9: assert property (@(posedge clk) disable iff (por)
        rst_oe |-> (ceo_n && !dout_en))
        else $error("R9: chip-enable-out low during reset");

    p_reset_gate_r4: assert property (@(posedge clk) disable iff (por)
        (rst_oe && ce_n) |=> (rd_addr == '0))
        else $error("R4: reset ignored with chip enable high");

endmodule

// File: tb/cfg_bitsrc_bench.sv
module cfg_bitsrc_bench;

    localparam int D  = 32;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          por = 1'b1;
    logic          rst_oe = 1'b1;
    logic          ce_a_n = 1'b1;
    logic          wr_a = 1'b0;
    logic          wr_b = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_bit = 1'b0;
    logic          dout_a, en_a, ceo_a_n;
    logic          dout_b, en_b, ceo_b_n;

    always #4 clk = ~clk;

    cfg_bitsrc #(.DEPTH(D)) u_cfg_bitsrc (
        .clk(clk), .por(por), .wr_en(wr_a), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .rst_oe(rst_oe), .ce_n(ce_a_n), .dout(dout_a), .dout_en(en_a), .ceo_n(ceo_a_n)
    );

    cfg_bitsrc #(.DEPTH(D)) u_cfg_bitsrc_b (
        .clk(clk), .por(por), .wr_en(wr_b), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .rst_oe(rst_oe), .ce_n(ceo_a_n), .dout(dout_b), .dout_en(en_b), .ceo_n(ceo_b_n)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit ended = 1'b0;

    // Behavioural reference state
    bit mem_a[D];
    bit mem_b[D];
    int ptr_a = 0, ptr_b = 0;
    bit fin_a = 1'b0, fin_b = 1'b0;
    bit valid = 1'b0;
    bit collect = 1'b0;
    bit stream_q[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycle(input bit p, input bit r, input bit ce, input bit wa, input bit wb,
                         input int adr, input bit val, input string tag);
        bit exp_en_a, exp_en_b, exp_ceo_a, exp_ceo_b, rs;
        @(negedge clk);
        por = p; rst_oe = r; ce_a_n = ce; wr_a = wa; wr_b = wb;
        wr_addr = AW'(adr); wr_bit = val;
        #1;
        rs = p || r;
        exp_en_a  = !rs && !ce && !fin_a;
        exp_ceo_a = rs || !fin_a;
        exp_en_b  = !rs && !exp_ceo_a && !fin_b;
        exp_ceo_b = rs || !fin_b;
        if (valid) begin
            chk(tag, "en_a", int'(en_a), int'(exp_en_a));
            chk(tag, "en_b", int'(en_b), int'(exp_en_b));
            chk(r ? "R9" : "R5", "ceo_a_n", int'(ceo_a_n), int'(exp_ceo_a));
            chk(r ? "R9" : "R5", "ceo_b_n", int'(ceo_b_n), int'(exp_ceo_b));
            chk("R8", "single driver", int'(en_a && en_b), 0);
            if (exp_en_a) chk(tag, "dout_a", int'(dout_a), int'(mem_a[ptr_a]));
            if (exp_en_b) chk(tag, "dout_b", int'(dout_b), int'(mem_b[ptr_b]));
            if (collect && en_a) stream_q.push_back(dout_a);
            else if (collect && en_b) stream_q.push_back(dout_b);
        end
        @(posedge clk);
        if (wa) mem_a[adr] = val;
        if (wb) mem_b[adr] = val;
        if (rs) begin
            ptr_a = 0; fin_a = 0; ptr_b = 0; fin_b = 0;
        end else begin
            if (!ce && !fin_a) begin
                if (ptr_a == D - 1) fin_a = 1; else ptr_a++;
            end
            if (!exp_ceo_a && !fin_b) begin
                if (ptr_b == D - 1) fin_b = 1; else ptr_b++;
            end
        end
        if (p) valid = 1'b1;
    endtask

    task automatic run(input bit r, input bit ce, input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(1'b0, r, ce, 1'b0, 1'b0, 0, 1'b0, tag);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !ended) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R6: power-on reset state
        cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 0, 1'b0, "R6");
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R6");
        // R7: load both memories through the write port
        for (int i = 0; i < D; i++)
            cycle(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, i, bit'(((i * 7 + 3) % 5) < 2), "R7");
        for (int i = 0; i < D; i++)
            cycle(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, i, bit'(((i * i + 1) % 3) == 0), "R7");
        run(1'b1, 1'b0, 3, "R1");
        run(1'b0, 1'b1, 4, "R2");
        collect = 1'b1;
        run(1'b0, 1'b0, 5, "R3");
        run(1'b0, 1'b1, 3, "R2");
        run(1'b0, 1'b0, 2 * D - 5, "R8");
        run(1'b0, 1'b0, 4, "R5");
        collect = 1'b0;
        begin
            bit mism;
            mism = (stream_q.size() != 2 * D);
            for (int i = 0; i < stream_q.size() && i < 2 * D; i++)
                if (stream_q[i] != (i < D ? mem_a[i] : mem_b[i - D])) mism = 1'b1;
            chk("R8", "concatenated stream length", stream_q.size(), 2 * D);
            chk("R8", "concatenated stream mismatch", int'(mism), 0);
        end
        run(1'b1, 1'b0, 1, "R9");
        run(1'b0, 1'b0, 10, "R3");
        run(1'b1, 1'b1, 2, "R4");
        run(1'b0, 1'b0, D + 3, "R8");
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, "R6");
        run(1'b0, 1'b0, 3, "R6");
        cycle(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 0, !mem_a[0], "R7");
        run(1'b0, 1'b0, 2, "R7");
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule